// File: doc/BRIEF.md
# Triggered Shadow Register and Error Status Bank

This block is the register side of a serial front-end control slave. A decoder ahead of it delivers one write or read per cycle as a decoded transaction: an address, a data byte, and a tag saying whether the frame addressed this slave individually, through its group identifier, or as a broadcast. Writes to the DAC value registers land in a shadow copy. They reach the active DAC output only when a trigger fires for that DAC, or at once when that DAC's trigger is masked.

The trigger/mode register combines the power-mode field, three trigger-mask bits and three self-clearing trigger bits. The mask that gates a trigger depends on the frame: an individual write uses the mask bits it carries itself, while group and broadcast writes use the mask already stored. The block also keeps a sticky error-status register. Its bits are set by single-cycle error pulses from the decoder and cleared by an individual read of the register. A soft-reset bit in the same register clears the working registers and leaves the trigger/mode register alone. Writing the startup code into the mode field resets everything and returns the mode to active.

Top module: `trig_shadow_regs`

## Requirements
- R1: After rst_n is released, both DAC outputs, both enables, the power mode, the masks and the status register are 0, and rd_ack is 0.
- R2: When the stored mask for DAC i is 1 (trigger register bit 3+i), an individual write to that DAC's address (0x02 + i) appears on its dac_value slice one clock after the write.
- R3: When the mask for DAC i is 0, a DAC write changes only the shadow. The output takes the shadow value one clock after a write of 1 to trigger bit i (bit i of register 0x1C).
- R4: In an individual write to 0x1C, trigger bit i is gated by mask bit 3+i of that same write. In a group write (wr_kind 01) or broadcast write (wr_kind 10), it is gated by the stored mask. An individual frame has wr_kind 00.
- R5: Only individual frames change the masks. Group and broadcast writes to 0x1C update only the mode field [7:6] and the triggers [2:0]. Group and broadcast writes to any other address have no effect.
- R6: When both enable bits are 0, DAC writes are ignored and the shadow and output keep their values. The enable register is at 0x00, with bit i enabling DAC i.
- R7: Status bit k (k = 0..6, register 0x1A) is set one clock after err_pulse[k] is high and stays set. Writes cannot set or clear bits [6:0].
- R8: An individual read of 0x1A returns the status, with bit 7 as 0, and clears the status register. An error pulse in the same cycle as the read stays set.
- R9: An individual write of 1 to bit 7 of 0x1A clears the DAC outputs, shadows, enables and status, and keeps the mode and masks. The same write in a group or broadcast frame does nothing.
- R10: Writing 01 to the mode field resets all registers, including the masks and status, and the mode then reads 00. Mode 11 leaves the stored mode unchanged, and modes 00 and 10 are stored.
- R11: An individual read of 0x00, 0x02+i, 0x1A or 0x1C raises rd_ack with the data one clock later. Group reads, broadcast reads and reads of other addresses give no rd_ack.
- R12: A read of 0x1C returns the mode in [7:6], the masks in [5:3] and 0 in [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| wr_valid | input | 1 | Decoded write present this cycle |
| wr_kind | input | 2 | Frame type of the write: 00 individual, 01 group, 10 broadcast |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Decoded read present this cycle |
| rd_kind | input | 2 | Frame type of the read, same coding as wr_kind |
| rd_addr | input | ADDR_W | Read register address |
| err_pulse | input | 7 | Error-detect pulses from the decoder, one per status bit |
| rd_ack | output | 1 | Read answered; rd_data valid |
| rd_data | output | DATA_W | Read data |
| dac_value | output | N_DAC*DAC_W | Active DAC values, DAC i in slice i |
| dac_enable | output | N_DAC | DAC enable bits |
| power_mode | output | 2 | Stored power mode |

## Verification
Every result here is due exactly one rising edge after the cycle that carries its stimulus. This covers a direct or triggered DAC update, a status bit set, a clear by read or reset, and the read reply. The bench applies each transaction at a falling edge and removes it at the next falling edge. At that second falling edge it compares the outputs with a reference model, which it updates once per transaction. A read reply is predicted from the model state before that transaction's update, because the register samples the pre-edge state.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    typedef enum logic [1:0] {
        FRM_UNIQUE = 2'b00,
        FRM_GROUP  = 2'b01,
        FRM_BCAST  = 2'b10
    } frame_kind_e;

    // Field positions inside the trigger/mode register
    localparam int TRG_LSB  = 0;
    localparam int MSK_LSB  = 3;
    localparam int MODE_LSB = 6;
    localparam int N_TRG    = 3;

    // Status register
    localparam int N_ERR    = 7;
    localparam int SRST_BIT = 7;

    localparam logic [1:0] MODE_ACTIVE  = 2'b00;
    localparam logic [1:0] MODE_STARTUP = 2'b01;
    localparam logic [1:0] MODE_RSVD    = 2'b11;

endpackage

// File: rtl/tsr_dac_slot.sv
module tsr_dac_slot #(
    parameter int DAC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic             direct_i,
    input  logic             fire_i,
    input  logic [DAC_W-1:0] wdata_i,
    output logic [DAC_W-1:0] act_o
);

    typedef struct packed {
        logic [DAC_W-1:0] act;
        logic [DAC_W-1:0] shd;
    } slot_t;

    slot_t d, q;

    always_comb begin
        d = q;
        if (load_i) begin
            d.shd = wdata_i;
            if (direct_i) d.act = wdata_i;
        end
        if (fire_i) d.act = q.shd;
        if (clr_i) begin
            d.act = '0;
            d.shd = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act_o = q.act;

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !fire_i && !clr_i) |=> $stable(q.act)); // R3

endmodule

// File: rtl/tsr_err_status.sv
module tsr_err_status #(
    parameter int N_BITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [N_BITS-1:0] err_i,
    output logic [N_BITS-1:0] stat_o
);

    logic [N_BITS-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = (clr_i ? '0 : stat_q) | err_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    AST_ERR_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i != '0) |=> ((stat_q & $past(err_i)) == $past(err_i))); // R8

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R7

endmodule

// File: rtl/trig_shadow_regs.sv
module trig_shadow_regs
    import tsr_pkg::*;
#(
    parameter int N_DAC       = 2,
    parameter int DAC_W       = 7,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int ADDR_ENABLE = 'h00,
    parameter int ADDR_DAC0   = 'h02,
    parameter int ADDR_STATUS = 'h1A,
    parameter int ADDR_TRIG   = 'h1C
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_valid,
    input  logic [1:0]             wr_kind,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   rd_valid,
    input  logic [1:0]             rd_kind,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [6:0]             err_pulse,
    output logic                   rd_ack,
    output logic [DATA_W-1:0]      rd_data,
    output logic [N_DAC*DAC_W-1:0] dac_value,
    output logic [N_DAC-1:0]       dac_enable,
    output logic [1:0]             power_mode
);

    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(ADDR_ENABLE);
    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_TRG = ADDR_W'(ADDR_TRIG);

    typedef struct packed {
        logic [N_DAC-1:0]  en;
        logic [N_TRG-1:0]  mask;
        logic [1:0]        mode;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t d, q;

    logic               wr_uniq, wr_known, rd_uniq;
    logic               trig_hit, startup, soft_rst, clr_all, stat_clr;
    logic [N_TRG-1:0]   eff_mask;
    logic [N_DAC-1:0]   load, fire;
    logic [DAC_W-1:0]   act_w [N_DAC];
    logic [N_ERR-1:0]   stat_w;

    always_comb begin
        wr_uniq  = wr_valid && (wr_kind == FRM_UNIQUE);
        wr_known = wr_valid && (wr_kind != 2'b11);
        rd_uniq  = rd_valid && (rd_kind == FRM_UNIQUE);
        trig_hit = wr_known && (wr_addr == A_TRG);
        startup  = trig_hit && (wr_data[MODE_LSB +: 2] == MODE_STARTUP);
        soft_rst = wr_uniq && (wr_addr == A_ST) && wr_data[SRST_BIT];
        clr_all  = startup || soft_rst;
        stat_clr = clr_all || (rd_uniq && (rd_addr == A_ST));
        eff_mask = wr_uniq ? wr_data[MSK_LSB +: N_TRG] : q.mask;

        // DAC write and trigger decode
        for (int i = 0; i < N_DAC; i++) begin
            load[i] = wr_uniq && (wr_addr == ADDR_W'(ADDR_DAC0 + i))
                      && (q.en != '0);
            fire[i] = trig_hit && !startup && wr_data[TRG_LSB + i]
                      && !eff_mask[i];
        end

        d = q;
        if (wr_uniq && (wr_addr == A_EN)) d.en = wr_data[N_DAC-1:0];
        if (trig_hit) begin
            if (wr_uniq) d.mask = wr_data[MSK_LSB +: N_TRG];
            if (wr_data[MODE_LSB +: 2] != MODE_RSVD) d.mode = wr_data[MODE_LSB +: 2];
        end
        if (soft_rst) d.en = '0;
        if (startup) begin
            d.en   = '0;
            d.mask = '0;
            d.mode = MODE_ACTIVE;
        end

        // Read reply
        d.ack   = 1'b0;
        d.rdata = '0;
        if (rd_uniq) begin
            if (rd_addr == A_EN) begin
                d.ack   = 1'b1;
                d.rdata = DATA_W'(q.en);
            end
            if (rd_addr == A_ST) begin
                d.ack   = 1'b1;
                d.rdata = DATA_W'(stat_w);
            end
            if (rd_addr == A_TRG) begin
                d.ack   = 1'b1;
                d.rdata = DATA_W'({q.mode, q.mask, 3'b000});
            end
            for (int i = 0; i < N_DAC; i++) begin
                if (rd_addr == ADDR_W'(ADDR_DAC0 + i)) begin
                    d.ack   = 1'b1;
                    d.rdata = DATA_W'(act_w[i]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    genvar g;
    generate
        for (g = 0; g < N_DAC; g++) begin : g_slot
            tsr_dac_slot #(.DAC_W(DAC_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr_i    (clr_all),
                .load_i   (load[g]),
                .direct_i (q.mask[g]),
                .fire_i   (fire[g]),
                .wdata_i  (wr_data[DAC_W-1:0]),
                .act_o    (act_w[g])
            );
            assign dac_value[g*DAC_W +: DAC_W] = act_w[g];
        end
    endgenerate

    tsr_err_status #(.N_BITS(N_ERR)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (stat_clr),
        .err_i  (err_pulse),
        .stat_o (stat_w)
    );

    assign rd_ack     = q.ack;
    assign rd_data    = q.rdata;
    assign dac_enable = q.en;
    assign power_mode = q.mode;

    AST_MASK_UNIQUE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_kind != FRM_UNIQUE
         && wr_data[MODE_LSB +: 2] != MODE_STARTUP) |=> $stable(q.mask)); // R5

    AST_DISABLED_NO_DAC_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.en == '0 && !trig_hit && !soft_rst) |=> $stable(dac_value)); // R6

    AST_NO_ACK_SHARED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_kind != FRM_UNIQUE) |=> !rd_ack); // R11

    AST_STATUS_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_uniq && rd_addr == A_ST) |=> (rd_ack && !rd_data[SRST_BIT])); // R8

endmodule

// File: tb/trig_shadow_regs_test.sv
module trig_shadow_regs_test;

    localparam int NDAC = 2;
    localparam int DW   = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, rd_valid = 1'b0;
    logic [1:0]  wr_kind = 2'b00, rd_kind = 2'b00;
    logic [4:0]  wr_addr = '0, rd_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [6:0]  err_pulse = '0;
    logic        rd_ack;
    logic [7:0]  rd_data;
    logic [NDAC*DW-1:0] dac_value;
    logic [NDAC-1:0]    dac_enable;
    logic [1:0]  power_mode;

    int checks = 0;
    int errors = 0;

    // reference model
    logic [6:0] m_act [NDAC];
    logic [6:0] m_sh  [NDAC];
    logic [1:0] m_en, m_mode;
    logic [2:0] m_mask;
    logic [6:0] m_stat;

    always #4 clk = ~clk;

    trig_shadow_regs uut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_kind(rd_kind), .rd_addr(rd_addr),
        .err_pulse(err_pulse),
        .rd_ack(rd_ack), .rd_data(rd_data),
        .dac_value(dac_value), .dac_enable(dac_enable), .power_mode(power_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset_all();
        for (int i = 0; i < NDAC; i++) begin
            m_act[i] = '0;
            m_sh[i]  = '0;
        end
        m_en = '0; m_mode = '0; m_mask = '0; m_stat = '0;
    endtask

    function automatic logic [7:0] model_read(input logic [4:0] a);
        if (a == 5'h00) return {6'b0, m_en};
        if (a == 5'h02) return {1'b0, m_act[0]};
        if (a == 5'h03) return {1'b0, m_act[1]};
        if (a == 5'h1A) return {1'b0, m_stat};
        if (a == 5'h1C) return {m_mode, m_mask, 3'b000};
        return 8'h00;
    endfunction

    function automatic bit addr_exists(input logic [4:0] a);
        return (a == 5'h00) || (a == 5'h02) || (a == 5'h03) || (a == 5'h1A) || (a == 5'h1C);
    endfunction

    task automatic model_write(input logic [1:0] k, input logic [4:0] a, input logic [7:0] dat);
        bit uniq = (k == 2'b00);
        bit clr = 0;
        logic [2:0] em;
        if (uniq && a == 5'h00) m_en = dat[1:0];
        for (int i = 0; i < NDAC; i++)
            if (uniq && a == 5'(2 + i) && m_en != 2'b00) begin
                m_sh[i] = dat[6:0];
                if (m_mask[i]) m_act[i] = dat[6:0];
            end
        if (uniq && a == 5'h1A && dat[7]) begin
            for (int i = 0; i < NDAC; i++) begin
                m_act[i] = '0;
                m_sh[i] = '0;
            end
            m_en = '0;
            clr = 1;
        end
        if (k != 2'b11 && a == 5'h1C) begin
            if (dat[7:6] == 2'b01) begin
                model_reset_all();
                clr = 1;
            end else begin
                em = uniq ? dat[5:3] : m_mask;
                for (int i = 0; i < NDAC; i++)
                    if (dat[i] && !em[i]) m_act[i] = m_sh[i];
                if (uniq) m_mask = dat[5:3];
                if (dat[7:6] != 2'b11) m_mode = dat[7:6];
            end
        end
        if (clr) m_stat = '0;
    endtask

    // one transaction: applied at a falling edge, checked at the next one
    task automatic op(input bit is_wr, input logic [1:0] k, input logic [4:0] a,
                      input logic [7:0] dat, input logic [6:0] err);
        bit exp_ack;
        logic [7:0] exp_data;
        exp_ack  = !is_wr && (k == 2'b00) && addr_exists(a);
        exp_data = model_read(a);
        wr_valid = is_wr;  wr_kind = k; wr_addr = a; wr_data = dat;
        rd_valid = !is_wr; rd_kind = k; rd_addr = a;
        err_pulse = err;
        @(posedge clk);
        if (is_wr) model_write(k, a, dat);
        else if (k == 2'b00 && a == 5'h1A) m_stat = '0;
        m_stat = m_stat | err;
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0; err_pulse = '0;
        check("R3 dac0", dac_value[DW-1:0], m_act[0]);
        check("R3 dac1", dac_value[2*DW-1:DW], m_act[1]);
        check("R6 enable", dac_enable, m_en);
        check("R10 mode", power_mode, m_mode);
        check("R11 ack", rd_ack, exp_ack);
        if (exp_ack) check("R11 data", rd_data, exp_data);
    endtask

    task automatic wr(input logic [1:0] k, input logic [4:0] a, input logic [7:0] dat);
        op(1'b1, k, a, dat, 7'h00);
    endtask

    task automatic rd(input logic [1:0] k, input logic [4:0] a);
        op(1'b0, k, a, 8'h00, 7'h00);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset_all();
        void'($urandom(32'd20151));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 dac", dac_value, '0);
        check("R1 en", dac_enable, '0);
        check("R1 mode", power_mode, '0);
        check("R1 ack", rd_ack, 1'b0);
        rd(2'b00, 5'h1A);
        check("R1 status", rd_data, 8'h00);

        // R2 direct write with mask0 stored
        wr(2'b00, 5'h00, 8'h03);
        wr(2'b00, 5'h1C, 8'b00_001_000);
        wr(2'b00, 5'h02, 8'h55);
        check("R2 direct", dac_value[6:0], 7'h55);
        // R3 shadow then trigger
        wr(2'b00, 5'h03, 8'h21);
        check("R3 held", dac_value[13:7], 7'h00);
        wr(2'b00, 5'h1C, 8'b00_001_010);
        check("R3 fired", dac_value[13:7], 7'h21);

        // R4 same-write mask in individual frame suppresses trigger
        wr(2'b00, 5'h03, 8'h33);
        wr(2'b00, 5'h1C, 8'b00_011_010);
        check("R4 uniq masked", dac_value[13:7], 7'h21);
        wr(2'b01, 5'h1C, 8'b00_000_010);
        check("R4 group stored mask", dac_value[13:7], 7'h21);
        wr(2'b00, 5'h1C, 8'b00_001_000);
        wr(2'b10, 5'h1C, 8'b00_111_010);
        check("R4 bcast fires", dac_value[13:7], 7'h33);
        // R5 / R12 masks unchanged by broadcast, read format
        rd(2'b00, 5'h1C);
        check("R12 trig read", rd_data, 8'h08);
        wr(2'b01, 5'h02, 8'h11);
        check("R5 group dac ignored", dac_value[6:0], 7'h55);
        wr(2'b10, 5'h00, 8'h00);
        check("R5 bcast enable ignored", dac_enable, 2'b11);

        // R6 disabled DAC writes ignored
        wr(2'b00, 5'h00, 8'h00);
        wr(2'b00, 5'h02, 8'h7F);
        check("R6 direct ignored", dac_value[6:0], 7'h55);
        wr(2'b00, 5'h03, 8'h44);
        wr(2'b00, 5'h00, 8'h02);
        wr(2'b00, 5'h1C, 8'b00_001_010);
        check("R6 shadow kept", dac_value[13:7], 7'h33);

        // R7 / R8 status
        op(1'b1, 2'b00, 5'h05, 8'h00, 7'h05);
        wr(2'b00, 5'h1A, 8'h7F);
        rd(2'b00, 5'h1A);
        check("R7 sticky not writable", rd_data, 8'h05);
        rd(2'b00, 5'h1A);
        check("R8 cleared", rd_data, 8'h00);
        op(1'b0, 2'b00, 5'h1A, 8'h00, 7'h08);
        check("R8 read before err", rd_data, 8'h00);
        rd(2'b00, 5'h1A);
        check("R8 err kept", rd_data, 8'h08);

        // R9 soft reset
        op(1'b1, 2'b00, 5'h05, 8'h00, 7'h10);
        wr(2'b01, 5'h1A, 8'h80);
        wr(2'b10, 5'h1A, 8'h80);
        check("R9 shared ignored", dac_value[6:0], 7'h55);
        wr(2'b00, 5'h1A, 8'h80);
        check("R9 dac cleared", dac_value, '0);
        check("R9 en cleared", dac_enable, 2'b00);
        rd(2'b00, 5'h1A);
        check("R9 status cleared", rd_data, 8'h00);
        rd(2'b00, 5'h1C);
        check("R9 trig kept", rd_data, 8'h08);

        // R10 mode handling
        wr(2'b10, 5'h1C, 8'b10_000_000);
        check("R10 low power", power_mode, 2'b10);
        wr(2'b00, 5'h1C, 8'b11_001_000);
        check("R10 reserved", power_mode, 2'b10);
        op(1'b1, 2'b00, 5'h05, 8'h00, 7'h01);
        wr(2'b00, 5'h00, 8'h01);
        wr(2'b00, 5'h02, 8'h12);
        wr(2'b00, 5'h1C, 8'b01_111_000);
        check("R10 startup dac", dac_value, '0);
        check("R10 startup mode", power_mode, 2'b00);
        rd(2'b00, 5'h1C);
        check("R10 masks reset", rd_data, 8'h00);
        rd(2'b00, 5'h1A);
        check("R10 status reset", rd_data, 8'h00);

        // R11 unanswered reads
        rd(2'b01, 5'h1A);
        check("R11 group read", rd_ack, 1'b0);
        rd(2'b10, 5'h00);
        check("R11 bcast read", rd_ack, 1'b0);
        rd(2'b00, 5'h05);
        check("R11 bad addr", rd_ack, 1'b0);

        // constrained random mix against the model
        for (int n = 0; n < 600; n++) begin
            logic [4:0] a;
            logic [7:0] dat;
            logic [1:0] k;
            logic [6:0] e;
            int sel = $urandom_range(0, 9);
            case (sel)
                0, 1:    a = 5'h02;
                2, 3:    a = 5'h03;
                4:       a = 5'h00;
                5:       a = 5'h1A;
                6, 7, 8: a = 5'h1C;
                default: a = 5'h07;
            endcase
            k = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 2)) : 2'b00;
            dat = 8'($urandom);
            if (a == 5'h1C && dat[7:6] == 2'b01 && $urandom_range(0, 3) != 0) dat[7:6] = 2'b00;
            if (a == 5'h1A && $urandom_range(0, 3) != 0) dat[7] = 1'b0;
            e = ($urandom_range(0, 7) == 0) ? 7'(1 << $urandom_range(0, 6)) : 7'h00;
            op($urandom_range(0, 9) < 7, k, a, dat, e);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule